// File: doc/BRIEF.md
# Noise Generator with Prescaled Period Timer

This block produces the pseudo-random noise waveform for one sound channel. A period timer is prescaled from a small table of eight divisors, and the chosen divisor is then multiplied by a power of two. Each time the timer runs out, a 15-bit shift register advances by one step. A mode bit shortens that register's feedback loop to give a 7-bit sequence with a buzzier tone.

The timer advances only on a machine-cycle enable. Each enable counts for four sub-ticks. A control byte selects the divisor, the shift and the sequence length, and it reads back unchanged. A trigger pulse reseeds the register and restarts the timer. The 4-bit output sample is either the supplied volume or zero, chosen by the register's lowest bit. It is forced to zero while the channel is inactive or its DAC is disabled. Envelope and length handling sit outside this block; the volume arrives as an input.

Top module: `noise_gen`

## Requirements
- R1: The timer period is the base divisor shifted left by the 4-bit shift field. The base divisor is 8 for code 0, and 16 times the code for codes 1 to 7.
- R2: On each cycle with `mcyc_en` high and no trigger, the timer does the following. A timer of zero is first replaced by the period. It then counts down by four sub-ticks. On the sub-tick that reaches zero it reloads with the full period and issues exactly one register step. Without `mcyc_en` the timer holds.
- R3: The shift register changes only on a timer step, a trigger or a reset.
- R4: On a step, the feedback bit is the XOR of register bits 0 and 1. The register shifts right by one place, and the feedback bit enters bit 14.
- R5: With the short-mode flag set (control bit 3 = 1), each step also writes the feedback bit into bit 6, after the shift.
- R6: The control byte holds three fields: shift in bits 7..4, short-mode flag in bit 3, divisor code in bits 2..0. A write with `cfg_we` appears on `cfg_rdata` on the next clock, exactly as written.
- R7: `sample` is registered. One clock after its inputs are seen, it equals `volume` when `chan_active` and `dac_en` are both high and register bit 0 is 0. Otherwise it is 0.
- R8: A trigger sets the register to 0x7FFF. It loads the timer with the period plus 4 when `chan_active` is low, or with twice the period plus 4 when it is high. A trigger takes precedence over `mcyc_en` in the same cycle.
- R9: Synchronous reset clears `sample`, the control byte and the timer, and sets the register to 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcyc_en | input | 1 | Machine-cycle enable, worth four timer sub-ticks |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read-back |
| trig | input | 1 | Trigger pulse: reseed register, restart timer |
| chan_active | input | 1 | Channel active flag |
| dac_en | input | 1 | DAC enable flag |
| volume | input | 4 | Current channel volume |
| sample | output | 4 | Noise sample output |

## Verification
The assertions rely on a few conditions on the inputs. The timer arithmetic relies on every period being at least 8, so the timer runs out at most once per machine cycle. The trigger-load check relies on `chan_active` describing the channel's state in the same cycle as the trigger. The stimulus sweeps every divisor code, both sequence lengths and small shifts. Each trigger is issued with a defined `chan_active`, often in the same cycle as an enable. Gaps in `mcyc_en`, DAC-off intervals and changing volumes are inserted, and every output is compared with an arithmetic model of the timer and register.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int CFG_W  = 8;
  localparam int LFSR_W = 15;

  typedef struct packed {
    logic [3:0] shift;
    logic       short_mode;
    logic [2:0] code;
  } noise_cfg_t;
endpackage

// File: rtl/noise_period.sv
module noise_period #(
  parameter int TMR_W = 24
) (
  input  logic [2:0]       code,
  input  logic [3:0]       shift,
  output logic [TMR_W-1:0] period
);
  localparam int BASE_W = 7;

  logic [BASE_W-1:0] base;

  // Non-power-of-two divisor table
  always_comb begin
    case (code)
      3'd0:    base = 7'd8;
      3'd1:    base = 7'd16;
      3'd2:    base = 7'd32;
      3'd3:    base = 7'd48;
      3'd4:    base = 7'd64;
      3'd5:    base = 7'd80;
      3'd6:    base = 7'd96;
      default: base = 7'd112;
    endcase
  end

  assign period = TMR_W'(base) << shift;
endmodule

// File: rtl/noise_timer.sv
module noise_timer #(
  parameter int TMR_W     = 24,
  parameter int SUB_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mcyc_en,
  input  logic             trig,
  input  logic             was_active,
  input  logic [TMR_W-1:0] period,
  output logic             step
);
  localparam logic [TMR_W-1:0] SUB   = TMR_W'(SUB_TICKS);
  localparam logic [TMR_W-1:0] DELAY = TMR_W'(4);

  logic [TMR_W-1:0] timer_q;
  logic [TMR_W-1:0] t_start;
  logic [TMR_W-1:0] t_after;
  logic             expire;

  // Period is always >= 8 > SUB_TICKS, so at most one expiry per enable
  always_comb begin
    t_start = (timer_q == '0) ? period : timer_q;
    if (t_start > SUB) begin
      t_after = t_start - SUB;
      expire  = 1'b0;
    end else begin
      t_after = period - (SUB - t_start);
      expire  = 1'b1;
    end
  end

  assign step = mcyc_en & ~trig & expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
    end else if (trig) begin
      timer_q <= was_active ? ((period << 1) + DELAY) : (period + DELAY);
    end else if (mcyc_en) begin
      timer_q <= t_after;
    end
  end

  AST_TICK_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mcyc_en && !trig && timer_q > SUB) |=> timer_q == $past(timer_q) - SUB); // R2
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mcyc_en && !trig) |=> $stable(timer_q)); // R2
  AST_TRIG_COLD: assert property (@(posedge clk) disable iff (rst)
    (trig && !was_active) |=> timer_q == $past(period) + DELAY); // R8
  AST_TRIG_WARM: assert property (@(posedge clk) disable iff (rst)
    (trig && was_active) |=> timer_q == ($past(period) << 1) + DELAY); // R8
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int LFSR_W    = 15,
  parameter int SHORT_TAP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              step,
  input  logic              short_mode,
  output logic [LFSR_W-1:0] lfsr_q
);
  localparam logic [LFSR_W-1:0] SEED = '1;

  logic              fb;
  logic [LFSR_W-1:0] lfsr_nxt;

  always_comb begin
    fb       = lfsr_q[0] ^ lfsr_q[1];
    lfsr_nxt = {fb, lfsr_q[LFSR_W-1:1]};
    if (short_mode) lfsr_nxt[SHORT_TAP] = fb;
  end

  always_ff @(posedge clk) begin
    if (rst || trig) lfsr_q <= SEED;
    else if (step)   lfsr_q <= lfsr_nxt;
  end

  AST_TRIG_SEED: assert property (@(posedge clk) disable iff (rst)
    trig |=> lfsr_q == SEED); // R8
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !trig) |=> $stable(lfsr_q)); // R3
  AST_FB_TOP: assert property (@(posedge clk) disable iff (rst)
    (step && !trig) |=> lfsr_q[LFSR_W-1] == ($past(lfsr_q[0]) ^ $past(lfsr_q[1]))); // R4
  AST_SHORT_TAP: assert property (@(posedge clk) disable iff (rst)
    (step && !trig && short_mode) |=> lfsr_q[SHORT_TAP] == ($past(lfsr_q[0]) ^ $past(lfsr_q[1]))); // R5
endmodule

// File: rtl/noise_gen.sv
module noise_gen #(
  parameter int TMR_W     = 24,
  parameter int SUB_TICKS = 4,
  parameter int VOL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mcyc_en,
  input  logic                       cfg_we,
  input  logic [noise_pkg::CFG_W-1:0] cfg_wdata,
  output logic [noise_pkg::CFG_W-1:0] cfg_rdata,
  input  logic                       trig,
  input  logic                       chan_active,
  input  logic                       dac_en,
  input  logic [VOL_W-1:0]           volume,
  output logic [VOL_W-1:0]           sample
);
  import noise_pkg::*;

  noise_cfg_t        cfg_q;
  logic [TMR_W-1:0]  period;
  logic              step;
  logic [LFSR_W-1:0] lfsr;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= noise_cfg_t'(cfg_wdata);
  end

  assign cfg_rdata = cfg_q;

  noise_period #(.TMR_W(TMR_W)) u_period (
    .code   (cfg_q.code),
    .shift  (cfg_q.shift),
    .period (period)
  );

  noise_timer #(.TMR_W(TMR_W), .SUB_TICKS(SUB_TICKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .mcyc_en    (mcyc_en),
    .trig       (trig),
    .was_active (chan_active),
    .period     (period),
    .step       (step)
  );

  noise_lfsr #(.LFSR_W(LFSR_W), .SHORT_TAP(6)) u_lfsr (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .step       (step),
    .short_mode (cfg_q.short_mode),
    .lfsr_q     (lfsr)
  );

  always_ff @(posedge clk) begin
    if (rst)                                   sample <= '0;
    else if (chan_active && dac_en && !lfsr[0]) sample <= volume;
    else                                       sample <= '0;
  end

  AST_SAMPLE_MUTE: assert property (@(posedge clk) disable iff (rst)
    !(chan_active && dac_en) |=> sample == '0); // R7
  AST_CFG_ECHO: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R6
endmodule

// File: tb/noise_gen_tb.sv
module noise_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mcyc_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       trig = 1'b0;
  logic       chan_active = 1'b1;
  logic       dac_en = 1'b1;
  logic [3:0] volume = 4'hF;
  logic [3:0] sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [14:0] m_lfsr = 15'h7FFF;
  int          m_timer = 0;
  logic [7:0]  m_cfg = 8'h00;

  always #2 clk = ~clk;

  noise_gen u_dut (
    .clk(clk), .rst(rst), .mcyc_en(mcyc_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
    .chan_active(chan_active), .dac_en(dac_en), .volume(volume),
    .sample(sample)
  );

  function automatic int m_period(input logic [7:0] c);
    int b;
    b = (c[2:0] == 3'd0) ? 8 : 16 * int'(c[2:0]);
    return b << c[7:4];
  endfunction

  function automatic logic [14:0] m_step(input logic [14:0] v, input logic sm);
    logic        fb;
    logic [14:0] r;
    fb = v[0] ^ v[1];
    r  = {fb, v[14:1]};
    if (sm) r[6] = fb;
    return r;
  endfunction

  task automatic chk(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // One clock: model from current drives, then compare after the edge
  task automatic cycle();
    int exp_s;
    int p;
    int t0;
    exp_s = (chan_active && dac_en && !m_lfsr[0]) ? int'(volume) : 0;
    p = m_period(m_cfg);
    if (trig) begin
      m_lfsr  = 15'h7FFF;
      m_timer = chan_active ? 2 * p + 4 : p + 4;
    end else if (mcyc_en) begin
      t0 = (m_timer == 0) ? p : m_timer;
      for (int k = 0; k < 4; k++) begin
        t0 = t0 - 1;
        if (t0 == 0) begin
          t0 = p;
          m_lfsr = m_step(m_lfsr, m_cfg[3]);
        end
      end
      m_timer = t0;
    end
    if (cfg_we) m_cfg = cfg_wdata;
    @(posedge clk);
    #1;
    chk("R1 R2 R3 R4 R5 R7 R8 sample", int'(sample), exp_s);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R9 reset sample", int'(sample), 0);
    chk("R9 reset cfg", int'(cfg_rdata), 0);

    // R9: free run from reset state, code 0, 15-bit
    for (int i = 0; i < 40; i++) begin
      mcyc_en = 1'b1;
      cycle();
    end

    for (int sh = 0; sh < 3; sh++) begin
      for (int md = 0; md < 2; md++) begin
        for (int cd = 0; cd < 8; cd++) begin
          cfg_we    = 1'b1;
          cfg_wdata = {4'(sh), 1'(md), 3'(cd)};
          mcyc_en   = 1'b1;
          cycle();
          cfg_we = 1'b0;
          chk("R6 readback", int'(cfg_rdata), int'({4'(sh), 1'(md), 3'(cd)}));
          chan_active = cd[0];
          trig = 1'b1;
          cycle();
          trig = 1'b0;
          chan_active = 1'b1;
          for (int i = 0; i < 120; i++) begin
            mcyc_en = (i % 5 != 4);
            dac_en  = !(i >= 60 && i < 64);
            volume  = 4'(i);
            cycle();
          end
          dac_en  = 1'b1;
          volume  = 4'hF;
          mcyc_en = 1'b0;
        end
      end
    end

    // R8: trigger while active, mid run with enable high
    cfg_we = 1'b1;
    cfg_wdata = 8'h08;
    cycle();
    cfg_we = 1'b0;
    for (int i = 0; i < 30; i++) begin
      mcyc_en = 1'b1;
      trig = (i == 11);
      cycle();
    end
    trig = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule